// File: doc/BRIEF.md
# Bus Cycle State Sequencer

This block times one external bus cycle for a small 16-bit processor core. The block clock `clk` runs at twice the bus rate, so every rising edge of `clk` starts a new half-clock state. The block brings out a bus clock `bus_clk` that is high in the even-numbered half and low in the odd one. A requester offers a single-word read or write together with an address, a direction and an access space. When the sequencer is ready, it takes the request and runs the states S0 to S5 while it drives the address, a three-bit function code, the direction line, an address strobe, a data strobe and a write-data enable. It samples the acknowledge input from the target at the end of S4. While the acknowledge is missing, it inserts wait states in pairs. It signals completion with a one-state `done` pulse in S5 and returns the read word on `rsp_rdata`.

States and transitions. The idle pair is IDLE_HI (bus clock high) and IDLE_LO (bus clock low). IDLE_HI always moves to IDLE_LO. IDLE_LO moves to S0 when `req_valid` is high (this is the accept) and back to IDLE_HI when it is low. S0 through S3 each step to the next state. S4 moves to S5 on an acknowledge or for a no-access cycle, and to WAIT_A otherwise. WAIT_A always moves to WAIT_B. WAIT_B makes the same decision as S4. S5 moves to IDLE_HI. Because the states alternate strictly between the two bus-clock halves, every cycle lasts an even number of states.

Space codes on `req_space`: 0 = user data, 1 = user program, 2 = supervisor data, 3 = supervisor program, 4 = interrupt acknowledge. Codes 5, 6 and 7 request an internal cycle with no memory access.

Top module: `bus_cycle_seq`

## Requirements
- R1: One state lasts one `clk` period. `bus_clk` is 1 in IDLE_HI, S0, S2, S4 and WAIT_B. It is 0 in IDLE_LO, S1, S3, S5 and WAIT_A. It therefore toggles on every `clk` edge.
- R2: `req_ready` is 1 only in IDLE_LO. A request is taken only when `req_valid` is 1 in IDLE_LO. Request inputs presented in any other state are ignored. After S5 the sequencer passes through IDLE_HI before it reaches IDLE_LO again.
- R3: An access cycle whose acknowledge is 1 at the end of S4 lasts exactly six states, S0 to S5.
- R4: If the acknowledge is 0 at the end of S4 or WAIT_B, the sequencer enters WAIT_A and then WAIT_B, and samples again at the end of WAIT_B. A cycle that sees N missing acknowledges lasts 6+2N states.
- R5: The function code of an access cycle comes from the space code: 0→001, 1→010, 2→101, 3→110, 4→111.
- R6: `bus_fc` never shows 000, 011 or 100. It is 101 after reset, and a no-access cycle leaves both it and `bus_addr` unchanged.
- R7: A no-access cycle (space 5, 6 or 7) lasts exactly six states whatever the acknowledge does. During it, `bus_as`, `bus_ds` and `bus_oe` stay 0 and `bus_rw` stays 1.
- R8: `bus_addr`, `bus_fc`, `bus_rw` and `bus_wdata` are loaded at the accept edge and stay stable from S0 through S5. `bus_rw` is 0 (write) only in S0..S5 and the wait states of a write cycle.
- R9: For an access cycle, `bus_as` is 1 in S1..S4 and in the wait states. `bus_ds` is 1 from S2 for a read or from S3 for a write, through S4 and the wait states. `bus_oe` is 1 in S1..S5 and the wait states of a write only.
- R10: `done` is 1 for exactly the S5 state. For a read, `rsp_rdata` takes `bus_rdata` at the edge where the acknowledge is accepted. At all other times `rsp_rdata` holds its value.
- R11: While reset is held, the state is IDLE_HI, `done` and all strobes are 0, `bus_rw` is 1, `bus_fc` is 101, and `bus_addr` and `rsp_rdata` are 0.
- R12: The acknowledge has no effect outside S4 and WAIT_B, so an early acknowledge does not shorten a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-state clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken in this state if valid |
| req_addr | input | AW | Word address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 3 | Access space code (see above) |
| req_wdata | input | DW | Write word |
| done | output | 1 | Cycle completes in this state (S5) |
| rsp_rdata | output | DW | Last word read |
| bus_clk | output | 1 | Bus clock, high in even states |
| bus_addr | output | AW | Bus address |
| bus_fc | output | 3 | Function code classifying the cycle |
| bus_rw | output | 1 | 1 = read or idle, 0 = write |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_oe | output | 1 | Write data drive enable |
| bus_wdata | output | DW | Write data to the bus |
| bus_ack | input | 1 | Transfer acknowledge from the target |
| bus_rdata | input | DW | Read data from the bus |

## Verification
The hardest situation to reach from the ports is a stall that repeats: the acknowledge is refused at S4 and again at one or more WAIT_B samples, while it is raised in the states where the sequencer must not look. To reach it, the bench drives the acknowledge from its own model of the position. It holds the acknowledge low at exactly the first N sample points and toggles it freely everywhere else. It also keeps `req_valid` high with changed fields during a running cycle, which shows that a request is taken only in IDLE_LO.

// File: rtl/bus_cycle_seq_pkg.sv
package bus_cycle_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE_HI,
        ST_IDLE_LO,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4,
        ST_S5,
        ST_WAIT_A,
        ST_WAIT_B
    } bstate_e;

    localparam logic [2:0] SP_UDATA = 3'd0;
    localparam logic [2:0] SP_UPROG = 3'd1;
    localparam logic [2:0] SP_SDATA = 3'd2;
    localparam logic [2:0] SP_SPROG = 3'd3;
    localparam logic [2:0] SP_IACK  = 3'd4;

    localparam logic [2:0] FC_UDATA = 3'b001;
    localparam logic [2:0] FC_UPROG = 3'b010;
    localparam logic [2:0] FC_SDATA = 3'b101;
    localparam logic [2:0] FC_SPROG = 3'b110;
    localparam logic [2:0] FC_IACK  = 3'b111;
    localparam logic [2:0] FC_RESET = FC_SDATA;

    function automatic logic space_is_access(input logic [2:0] sp);
        return (sp <= SP_IACK);
    endfunction

    function automatic logic [2:0] space_to_fc(input logic [2:0] sp);
        logic [2:0] fc;
        unique case (sp)
            SP_UDATA: fc = FC_UDATA;
            SP_UPROG: fc = FC_UPROG;
            SP_SDATA: fc = FC_SDATA;
            SP_SPROG: fc = FC_SPROG;
            SP_IACK:  fc = FC_IACK;
            default:  fc = FC_RESET;
        endcase
        return fc;
    endfunction

endpackage

// File: rtl/bus_cycle_seq_fsm.sv
module bus_cycle_seq_fsm
    import bus_cycle_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    acc_q,
    input  logic    bus_ack,
    output bstate_e state,
    output logic    accept,
    output logic    ack_take
);

    bstate_e nxt;
    logic    sample_pt;

    assign sample_pt = (state == ST_S4) || (state == ST_WAIT_B);
    assign accept    = (state == ST_IDLE_LO) && req_valid;
    assign ack_take  = sample_pt && acc_q && bus_ack;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE_HI: nxt = ST_IDLE_LO;
            ST_IDLE_LO: nxt = req_valid ? ST_S0 : ST_IDLE_HI;
            ST_S0:      nxt = ST_S1;
            ST_S1:      nxt = ST_S2;
            ST_S2:      nxt = ST_S3;
            ST_S3:      nxt = ST_S4;
            ST_S4,
            ST_WAIT_B:  nxt = (!acc_q || bus_ack) ? ST_S5 : ST_WAIT_A;
            ST_WAIT_A:  nxt = ST_WAIT_B;
            ST_S5:      nxt = ST_IDLE_HI;
            default:    nxt = ST_IDLE_HI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE_HI;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/bus_cycle_seq_latch.sv
module bus_cycle_seq_latch
    import bus_cycle_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          ack_take,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [2:0]    req_space,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] addr_q,
    output logic [2:0]    fc_q,
    output logic          wr_q,
    output logic          acc_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);

    logic take_access;

    assign take_access = accept && space_is_access(req_space);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
        end else if (accept) begin
            acc_q <= space_is_access(req_space);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            fc_q    <= FC_RESET;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (take_access) begin
            addr_q  <= req_addr;
            fc_q    <= space_to_fc(req_space);
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (ack_take && !wr_q) begin
            rdata_q <= bus_rdata;
        end
    end

endmodule

// File: rtl/bus_cycle_seq_drive.sv
module bus_cycle_seq_drive
    import bus_cycle_seq_pkg::*;
(
    input  bstate_e state,
    input  logic    acc_q,
    input  logic    wr_q,
    output logic    bus_clk,
    output logic    bus_as,
    output logic    bus_ds,
    output logic    bus_oe,
    output logic    bus_rw,
    output logic    done,
    output logic    req_ready
);

    logic in_cycle;
    logic in_wait;
    logic as_win;
    logic ds_win;
    logic oe_win;

    always_comb begin
        bus_clk  = 1'b0;
        in_cycle = 1'b1;
        in_wait  = 1'b0;
        as_win   = 1'b0;
        ds_win   = 1'b0;
        oe_win   = 1'b0;
        unique case (state)
            ST_IDLE_HI: begin bus_clk = 1'b1; in_cycle = 1'b0; end
            ST_IDLE_LO: begin in_cycle = 1'b0; end
            ST_S0:      begin bus_clk = 1'b1; end
            ST_S1:      begin as_win = 1'b1; oe_win = 1'b1; end
            ST_S2:      begin bus_clk = 1'b1; as_win = 1'b1; oe_win = 1'b1;
                              ds_win = !wr_q; end
            ST_S3:      begin as_win = 1'b1; oe_win = 1'b1; ds_win = 1'b1; end
            ST_S4:      begin bus_clk = 1'b1; as_win = 1'b1; oe_win = 1'b1;
                              ds_win = 1'b1; end
            ST_WAIT_A:  begin in_wait = 1'b1; end
            ST_WAIT_B:  begin bus_clk = 1'b1; in_wait = 1'b1; end
            ST_S5:      begin oe_win = 1'b1; end
            default:    begin in_cycle = 1'b0; end
        endcase
    end

    assign bus_as    = acc_q && (as_win || in_wait);
    assign bus_ds    = acc_q && (ds_win || in_wait);
    assign bus_oe    = acc_q && wr_q && (oe_win || in_wait);
    assign bus_rw    = !(acc_q && wr_q && in_cycle);
    assign done      = (state == ST_S5);
    assign req_ready = (state == ST_IDLE_LO);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_cycle_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [2:0]    req_space,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_clk,
    output logic [AW-1:0] bus_addr,
    output logic [2:0]    bus_fc,
    output logic          bus_rw,
    output logic          bus_as,
    output logic          bus_ds,
    output logic          bus_oe,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);

    bstate_e state;
    logic    accept;
    logic    ack_take;
    logic    acc_q;
    logic    wr_q;

    bus_cycle_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .acc_q    (acc_q),
        .bus_ack  (bus_ack),
        .state    (state),
        .accept   (accept),
        .ack_take (ack_take)
    );

    bus_cycle_seq_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .ack_take (ack_take),
        .req_addr (req_addr),
        .req_write(req_write),
        .req_space(req_space),
        .req_wdata(req_wdata),
        .bus_rdata(bus_rdata),
        .addr_q   (bus_addr),
        .fc_q     (bus_fc),
        .wr_q     (wr_q),
        .acc_q    (acc_q),
        .wdata_q  (bus_wdata),
        .rdata_q  (rsp_rdata)
    );

    bus_cycle_seq_drive u_drive (
        .state    (state),
        .acc_q    (acc_q),
        .wr_q     (wr_q),
        .bus_clk  (bus_clk),
        .bus_as   (bus_as),
        .bus_ds   (bus_ds),
        .bus_oe   (bus_oe),
        .bus_rw   (bus_rw),
        .done     (done),
        .req_ready(req_ready)
    );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic          bus_clk,
    input logic          bus_as,
    input logic          bus_ds,
    input logic          bus_oe,
    input logic          bus_rw,
    input logic [2:0]    bus_fc,
    input logic [AW-1:0] bus_addr
);

    p_clk_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk |=> !bus_clk);

    p_clk_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_clk |=> bus_clk);

    p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_as && !bus_oe && !done));

    p_fc_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fc != 3'b000) && (bus_fc != 3'b011) && (bus_fc != 3'b100));

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && $past(bus_as)) |-> ($stable(bus_addr) && $stable(bus_fc)));

    p_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !bus_rw);

    p_ds_in_as_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ds |-> bus_as);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && bus_clk));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .done     (done),
    .bus_clk  (bus_clk),
    .bus_as   (bus_as),
    .bus_ds   (bus_ds),
    .bus_oe   (bus_oe),
    .bus_rw   (bus_rw),
    .bus_fc   (bus_fc),
    .bus_addr (bus_addr)
);

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int P_IH = -2;
    localparam int P_IL = -1;
    localparam int P_WA = 10;
    localparam int P_WB = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [2:0]    req_space = 3'd0;
    logic [DW-1:0] req_wdata = '0;
    logic          done;
    logic [DW-1:0] rsp_rdata;
    logic          bus_clk;
    logic [AW-1:0] bus_addr;
    logic [2:0]    bus_fc;
    logic          bus_rw;
    logic          bus_as;
    logic          bus_ds;
    logic          bus_oe;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #2 clk = ~clk;

    bus_cycle_seq #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_space(req_space),
        .req_wdata(req_wdata), .done(done), .rsp_rdata(rsp_rdata),
        .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_rw(bus_rw),
        .bus_as(bus_as), .bus_ds(bus_ds), .bus_oe(bus_oe), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit started = 0;
    bit finished = 0;

    // behavioural reference
    int            m_pos = P_IH;
    logic [2:0]    m_fc = 3'b101;
    logic [AW-1:0] m_addr = '0;
    logic          m_wr = 1'b0;
    logic          m_acc = 1'b0;
    logic [DW-1:0] m_wd = '0;
    logic [DW-1:0] m_rd = '0;
    int            m_nw = 0;
    int            m_samp = 0;
    int            tb_nwait = 0;
    bit            noise_en = 0;

    function automatic logic [2:0] exp_fc(input logic [2:0] sp);
        case (sp)
            3'd0: return 3'b001;
            3'd1: return 3'b010;
            3'd2: return 3'b101;
            3'd3: return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (!rst_n) begin
            m_pos = P_IH; m_fc = 3'b101; m_addr = '0; m_wr = 0;
            m_acc = 0; m_wd = '0; m_rd = '0;
        end else begin
            if (m_pos == P_IH) m_pos = P_IL;
            else if (m_pos == P_IL) begin
                if (req_valid) begin
                    m_acc = (req_space <= 3'd4);
                    if (m_acc) begin
                        m_addr = req_addr; m_fc = exp_fc(req_space);
                        m_wr = req_write; m_wd = req_wdata;
                    end
                    m_nw = tb_nwait; m_samp = 0; m_pos = 0;
                end else m_pos = P_IH;
            end else if (m_pos == 4 || m_pos == P_WB) begin
                if (!m_acc || bus_ack) begin
                    if (m_acc && !m_wr) m_rd = bus_rdata;
                    m_pos = 5;
                end else m_pos = P_WA;
                m_samp++;
            end else if (m_pos == P_WA) m_pos = P_WB;
            else if (m_pos == 5) m_pos = P_IH;
            else m_pos++;
        end
    end

    always @(negedge clk) begin
        bit act, in_w, e_clk, e_as, e_ds, e_oe, e_rw;
        if (started && rst_n && !finished) begin
            act   = (m_pos >= 0);
            in_w  = (m_pos >= P_WA);
            e_clk = (m_pos == P_IH) || (m_pos == 0) || (m_pos == 2) ||
                    (m_pos == 4) || (m_pos == P_WB);
            e_as  = m_acc && ((m_pos >= 1 && m_pos <= 4) || in_w);
            e_ds  = m_acc && ((m_pos >= (m_wr ? 3 : 2) && m_pos <= 4) || in_w);
            e_oe  = m_acc && m_wr && ((m_pos >= 1 && m_pos <= 5) || in_w);
            e_rw  = !(m_acc && m_wr && act);
            chk("R1", "bus_clk", 32'(bus_clk), 32'(e_clk));
            chk("R2", "req_ready", 32'(req_ready), 32'(m_pos == P_IL));
            chk("R10", "done", 32'(done), 32'(m_pos == 5));
            chk("R10", "rsp_rdata", 32'(rsp_rdata), 32'(m_rd));
            chk("R5", "bus_fc", 32'(bus_fc), 32'(m_fc));
            chk("R8", "bus_addr", 32'(bus_addr), 32'(m_addr));
            chk("R8", "bus_rw", 32'(bus_rw), 32'(e_rw));
            chk("R9", "bus_as", 32'(bus_as), 32'(e_as));
            chk("R9", "bus_ds", 32'(bus_ds), 32'(e_ds));
            chk("R9", "bus_oe", 32'(bus_oe), 32'(e_oe));
            if (e_oe) chk("R8", "bus_wdata", 32'(bus_wdata), 32'(m_wd));
        end
        // acknowledge and read data stimulus
        bus_rdata = DW'(16'hA000 ^ cyc[15:0]);
        if ((m_pos == 4 || m_pos == P_WB) && m_acc)
            bus_ack = (m_samp == m_nw);
        else
            bus_ack = noise_en && cyc[0];
    end

    task automatic run_cycle(input logic [AW-1:0] a, input logic wr,
                             input logic [2:0] sp, input logic [DW-1:0] wd,
                             input int nw, input bit noise, input bit keep,
                             input string tag);
        int len;
        @(negedge clk);
        tb_nwait = nw; noise_en = noise;
        req_valid = 1; req_addr = a; req_write = wr; req_space = sp; req_wdata = wd;
        while (m_pos != 0) @(negedge clk);
        if (keep) begin
            // R2: new fields shown mid-cycle must not be taken
            req_addr = ~a; req_space = 3'd1; req_wdata = ~wd;
        end else req_valid = 0;
        len = 1;
        while (!done) begin
            @(negedge clk);
            len++;
        end
        chk(tag, "cycle length", 32'(len), 32'(6 + 2 * nw));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset done", 32'(done), 32'(0));
        chk("R11", "reset bus_fc", 32'(bus_fc), 32'(3'b101));
        chk("R11", "reset strobes", 32'({bus_as, bus_ds, bus_oe}), 32'(0));
        chk("R11", "reset bus_rw", 32'(bus_rw), 32'(1));
        chk("R11", "reset addr/rdata", 32'({bus_addr, rsp_rdata}), 32'(0));
        chk("R11", "reset bus_clk", 32'(bus_clk), 32'(1));
        rst_n = 1;
        repeat (3) @(negedge clk);
        run_cycle(16'h1234, 0, 3'd0, 16'h0000, 0, 0, 0, "R3");
        run_cycle(16'h2222, 1, 3'd1, 16'hBEEF, 1, 0, 0, "R4");
        run_cycle(16'h3333, 0, 3'd2, 16'h0000, 3, 1, 0, "R12");
        run_cycle(16'h4444, 1, 3'd3, 16'h5A5A, 0, 1, 1, "R3");
        run_cycle(16'h5555, 0, 3'd4, 16'h0000, 2, 0, 0, "R4");
        run_cycle(16'h6666, 1, 3'd5, 16'h1111, 0, 1, 0, "R7");
        chk("R6", "fc kept after no-access", 32'(bus_fc), 32'(3'b111));
        chk("R6", "addr kept after no-access", 32'(bus_addr), 32'(16'h5555));
        run_cycle(16'h7777, 0, 3'd6, 16'h0000, 0, 0, 0, "R7");
        run_cycle(16'h7878, 1, 3'd7, 16'h2222, 0, 1, 0, "R7");
        chk("R6", "fc kept after spaces 6/7", 32'(bus_fc), 32'(3'b111));
        run_cycle(16'h8888, 0, 3'd0, 16'h0000, 4, 1, 0, "R4");
        run_cycle(16'h9999, 1, 3'd2, 16'hC3C3, 2, 1, 0, "R12");
        req_valid = 0;
        repeat (10) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule